// File: doc/BRIEF.md
# Path Gain Shift and Rounding Stage

This stage sits after a summing network. It takes six signed path values, named ia, qa, ib, qb, ic and id. Each value is `IN_W` bits wide.

The stage applies gain and then reduces precision:

- **Gain.** The four summed paths (ia, qa, ib, qb) share a programmable left shift of 0 to 7. The two direct paths (ic, id) never pass through that shifter. Instead they carry a fixed gain of 2^`FIXED_SH`, which is 8 by default. A shift setting equal to `FIXED_SH` therefore gives all six paths the same gain.
- **Precision.** Every shifted path is rounded half-up and then saturated. The result is either a wide word (22 bits), used when partial sums travel down a chain of devices, or a narrow word (16 bits).

A device in the middle of a chain is run with shift 0 and the chain's own precision. Only the last device applies a real shift and rounds to what the next stage needs.

The round and saturate result is registered once. The output valid flag is the input strobe delayed by one clock. While no strobe is present, the outputs hold their last value.

Top module: `path_gain_round`

## Requirements
- R1: With `in_narrow`=0 and no saturation, each of ia, qa, ib and qb produces floor((x·2^s + 2^(D_W−1)) / 2^D_W). Here s is `in_shift` (0..7) and D_W = `IN_W`−22. All four paths use the same s.
- R2: Paths ic and id ignore `in_shift`. They are always scaled by 2^`FIXED_SH` (default 3) before rounding.
- R3: When `in_shift` equals `FIXED_SH`, equal input values on ia and ic give equal outputs on ia and ic.
- R4: Wide mode (`in_narrow`=0) drops the `IN_W`−22 low bits and rounds half up: an exact half LSB rounds toward plus infinity, so +2 gives 1 and −2 gives 0 when `IN_W`=24.
- R5: Narrow mode (`in_narrow`=1) drops `IN_W`−16 low bits with the same round-half-up rule. The result is a 16-bit value, sign-extended onto the 22-bit output port.
- R6: A rounded result above the target range gives the most positive code of the selected width: 2^21−1 in wide mode, 2^15−1 in narrow mode. A result below the range gives the most negative code: −2^21 or −2^15.
- R7: `out_valid` equals `in_valid` from the previous clock, and the data that comes with it belongs to that same strobe.
- R8: A clock edge with `in_valid`=0 leaves all six outputs unchanged.
- R9: While `rst_n` is low, `out_valid` and all six outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_shift | input | SH_W (3) | Left shift for ia, qa, ib and qb |
| in_narrow | input | 1 | 0: round to 22 bits, 1: round to 16 bits |
| in_ia | input | IN_W | Summed path ia, signed |
| in_qa | input | IN_W | Summed path qa, signed |
| in_ib | input | IN_W | Summed path ib, signed |
| in_qb | input | IN_W | Summed path qb, signed |
| in_ic | input | IN_W | Direct path ic, signed |
| in_id | input | IN_W | Direct path id, signed |
| out_valid | output | 1 | Output strobe, one clock after in_valid |
| out_ia | output | WIDE_W | Rounded ia |
| out_qa | output | WIDE_W | Rounded qa |
| out_ib | output | WIDE_W | Rounded ib |
| out_qb | output | WIDE_W | Rounded qb |
| out_ic | output | WIDE_W | Rounded ic |
| out_id | output | WIDE_W | Rounded id |

## Verification
Some properties are checked on every clock:

- the one-clock valid delay and the hold of all outputs when no strobe is present;
- equal results for equal inputs on paths that share a gain;
- the gain match between ia and ic at the matching shift;
- the 16-bit range bound in narrow mode.

Other behaviour needs the bench's computed reference values:

- the exact rounded values, including the half-LSB tie in both directions;
- the saturation to each limit;
- the direct paths' independence from the shift setting;
- the zero state during reset.

// File: rtl/path_gain_round.sv
module path_gain_round #(
  parameter int IN_W     = 24,
  parameter int WIDE_W   = 22,
  parameter int NARROW_W = 16,
  parameter int SH_W     = 3,
  parameter int FIXED_SH = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [SH_W-1:0]          in_shift,
  input  logic                     in_narrow,
  input  logic signed [IN_W-1:0]   in_ia,
  input  logic signed [IN_W-1:0]   in_qa,
  input  logic signed [IN_W-1:0]   in_ib,
  input  logic signed [IN_W-1:0]   in_qb,
  input  logic signed [IN_W-1:0]   in_ic,
  input  logic signed [IN_W-1:0]   in_id,
  output logic                     out_valid,
  output logic signed [WIDE_W-1:0] out_ia,
  output logic signed [WIDE_W-1:0] out_qa,
  output logic signed [WIDE_W-1:0] out_ib,
  output logic signed [WIDE_W-1:0] out_qb,
  output logic signed [WIDE_W-1:0] out_ic,
  output logic signed [WIDE_W-1:0] out_id
);
  localparam int NPATH    = 6;
  localparam int NSHIFTED = 4;
  localparam int EXT_W    = IN_W + (1 << SH_W) + 1;
  localparam int D_WIDE   = IN_W - WIDE_W;
  localparam int D_NARROW = IN_W - NARROW_W;

  localparam logic signed [EXT_W-1:0] HALF_WIDE   = EXT_W'(1) << (D_WIDE - 1);
  localparam logic signed [EXT_W-1:0] HALF_NARROW = EXT_W'(1) << (D_NARROW - 1);
  localparam logic signed [EXT_W-1:0] MAX_WIDE    = (EXT_W'(1) << (WIDE_W - 1)) - EXT_W'(1);
  localparam logic signed [EXT_W-1:0] MAX_NARROW  = (EXT_W'(1) << (NARROW_W - 1)) - EXT_W'(1);
  localparam logic signed [EXT_W-1:0] MIN_WIDE    = -MAX_WIDE - EXT_W'(1);
  localparam logic signed [EXT_W-1:0] MIN_NARROW  = -MAX_NARROW - EXT_W'(1);

  function automatic logic signed [WIDE_W-1:0] shape(
    input logic signed [IN_W-1:0] x,
    input logic [SH_W-1:0]        sh,
    input logic                   narrow
  );
    logic signed [EXT_W-1:0] v;
    logic signed [EXT_W-1:0] r;
    logic signed [EXT_W-1:0] hi;
    logic signed [EXT_W-1:0] lo;
    v  = {{(EXT_W-IN_W){x[IN_W-1]}}, x};
    v  = v <<< sh;
    if (narrow) begin
      r  = (v + HALF_NARROW) >>> D_NARROW;
      hi = MAX_NARROW;
      lo = MIN_NARROW;
    end else begin
      r  = (v + HALF_WIDE) >>> D_WIDE;
      hi = MAX_WIDE;
      lo = MIN_WIDE;
    end
    if (r > hi)      r = hi;
    else if (r < lo) r = lo;
    return r[WIDE_W-1:0];
  endfunction

  logic signed [IN_W-1:0]   path_in  [NPATH];
  logic signed [WIDE_W-1:0] path_nxt [NPATH];
  logic signed [WIDE_W-1:0] path_q   [NPATH];

  assign path_in[0] = in_ia;
  assign path_in[1] = in_qa;
  assign path_in[2] = in_ib;
  assign path_in[3] = in_qb;
  assign path_in[4] = in_ic;
  assign path_in[5] = in_id;

  for (genvar g = 0; g < NPATH; g++) begin : g_path
    if (g < NSHIFTED) begin : g_shifted
      assign path_nxt[g] = shape(path_in[g], in_shift, in_narrow);
    end else begin : g_fixed
      assign path_nxt[g] = shape(path_in[g], SH_W'(FIXED_SH), in_narrow);
    end

    always_ff @(posedge clk) begin
      if (!rst_n)        path_q[g] <= '0;
      else if (in_valid) path_q[g] <= path_nxt[g];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= in_valid;
  end

  assign out_ia = path_q[0];
  assign out_qa = path_q[1];
  assign out_ib = path_q[2];
  assign out_qb = path_q[3];
  assign out_ic = path_q[4];
  assign out_id = path_q[5];
endmodule

// File: rtl/path_gain_round_chk.sv
module path_gain_round_chk #(
  parameter int IN_W     = 24,
  parameter int WIDE_W   = 22,
  parameter int NARROW_W = 16,
  parameter int SH_W     = 3,
  parameter int FIXED_SH = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     in_valid,
  input logic [SH_W-1:0]          in_shift,
  input logic                     in_narrow,
  input logic signed [IN_W-1:0]   in_ia,
  input logic signed [IN_W-1:0]   in_qa,
  input logic signed [IN_W-1:0]   in_ib,
  input logic signed [IN_W-1:0]   in_qb,
  input logic signed [IN_W-1:0]   in_ic,
  input logic signed [IN_W-1:0]   in_id,
  input logic                     out_valid,
  input logic signed [WIDE_W-1:0] out_ia,
  input logic signed [WIDE_W-1:0] out_qa,
  input logic signed [WIDE_W-1:0] out_ib,
  input logic signed [WIDE_W-1:0] out_qb,
  input logic signed [WIDE_W-1:0] out_ic,
  input logic signed [WIDE_W-1:0] out_id
);
  localparam logic signed [WIDE_W-1:0] N_MAX = WIDE_W'((1 << (NARROW_W - 1)) - 1);
  localparam logic signed [WIDE_W-1:0] N_MIN = -N_MAX - WIDE_W'(1);

  AST_VALID_SET: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R7
  AST_VALID_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R7
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_ia) && $stable(out_qa) && $stable(out_ib)
               && $stable(out_qb) && $stable(out_ic) && $stable(out_id)); // R8
  AST_SHARED_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (in_ia == in_qb) |=> out_ia == out_qb); // R1
  AST_DIRECT_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (in_ic == in_id) |=> out_ic == out_id); // R2
  AST_GAIN_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (in_shift == SH_W'(FIXED_SH)) && (in_ia == in_ic) |=> out_ia == out_ic); // R3
  AST_NARROW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_narrow |=> out_ia <= N_MAX && out_ia >= N_MIN
                           && out_ic <= N_MAX && out_ic >= N_MIN); // R5
endmodule

bind path_gain_round path_gain_round_chk #(
  .IN_W(IN_W), .WIDE_W(WIDE_W), .NARROW_W(NARROW_W), .SH_W(SH_W), .FIXED_SH(FIXED_SH)
) chk_i (.*);

// File: tb/path_gain_round_tb.sv
`timescale 1ns/1ps
module path_gain_round_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [2:0] in_shift = '0;
  logic in_narrow = 1'b0;
  logic signed [23:0] x [6];
  logic out_valid;
  logic signed [21:0] y [6];

  int checks = 0;
  int failures = 0;
  bit done = 0;

  longint e [6];
  bit es [6];
  bit ev = 0;
  bit eh = 0;

  always #4 clk = ~clk;

  path_gain_round dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_shift(in_shift), .in_narrow(in_narrow),
    .in_ia(x[0]), .in_qa(x[1]), .in_ib(x[2]), .in_qb(x[3]), .in_ic(x[4]), .in_id(x[5]),
    .out_valid(out_valid),
    .out_ia(y[0]), .out_qa(y[1]), .out_ib(y[2]), .out_qb(y[3]), .out_ic(y[4]), .out_id(y[5])
  );

  function automatic longint ref_val(longint v_in, int sh, bit narrow, output bit sat);
    longint v, r, hi;
    int d;
    d  = narrow ? 8 : 2;
    hi = narrow ? 32767 : 2097151;
    v  = v_in * (longint'(1) << sh);
    r  = (v + (longint'(1) << (d - 1))) >>> d;
    sat = 0;
    if (r > hi) begin r = hi; sat = 1; end
    else if (r < -hi - 1) begin r = -hi - 1; sat = 1; end
    return r;
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cycle(bit v, int sh, bit nar, longint a0, longint a1, longint a2,
                       longint a3, longint a4, longint a5);
    longint a [6];
    bit s;
    a = '{a0, a1, a2, a3, a4, a5};
    in_valid = v; in_shift = 3'(sh); in_narrow = nar;
    for (int i = 0; i < 6; i++) x[i] = 24'(a[i]);
    eh = !v;
    ev = v;
    if (v) for (int i = 0; i < 6; i++) begin
      e[i]  = ref_val(longint'(x[i]), (i < 4) ? sh : 3, nar, s);
      es[i] = s;
    end
    @(negedge clk);
    chk("R7", longint'(out_valid), longint'(ev));
    for (int i = 0; i < 6; i++) begin
      string tag;
      if (eh)         tag = "R8";
      else if (es[i]) tag = "R6";
      else if (i >= 4) tag = "R2";
      else            tag = nar ? "R5" : "R1";
      chk(tag, longint'(y[i]), e[i]);
    end
  endtask

  initial begin
    #(8ns * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 6; i++) begin x[i] = '0; e[i] = 0; es[i] = 0; end
    repeat (3) @(negedge clk);
    chk("R9", longint'(out_valid), 0);
    for (int i = 0; i < 6; i++) chk("R9", longint'(y[i]), 0);
    rst_n = 1'b1;

    // R4 half-LSB ties in wide mode: +2 -> 1, -2 -> 0, +6 -> 2
    cycle(1, 0, 0, 2, -2, 6, -6, 1, -1);
    chk("R4", longint'(y[0]), 1);
    chk("R4", longint'(y[1]), 0);
    // R5 narrow tie: 128 -> 1, -128 -> 0
    cycle(1, 0, 1, 128, -128, 127, -129, 16, -16);
    chk("R5", longint'(y[0]), 1);
    chk("R5", longint'(y[1]), 0);
    // R3 gain match at shift 3
    cycle(1, 3, 0, 12345, -777, 5, 9, 12345, -777);
    chk("R3", longint'(y[0]), longint'(y[4]));
    chk("R3", longint'(y[1]), longint'(y[5]));
    // R2 direct paths unaffected by shift
    cycle(1, 7, 0, 1000, 1000, 1000, 1000, 1000, 1000);
    chk("R2", longint'(y[4]), 2000);
    // R6 saturation both ends, both widths
    cycle(1, 7, 0, 8388607, -8388608, 40000, -40000, 8388607, -8388608);
    chk("R6", longint'(y[0]), 2097151);
    chk("R6", longint'(y[1]), -2097152);
    cycle(1, 1, 1, 8388607, -8388608, 4194304, -4194305, 8388607, -8388608);
    chk("R6", longint'(y[0]), 32767);
    chk("R6", longint'(y[1]), -32768);
    // R8 hold with changed inputs
    cycle(0, 5, 0, 1, 2, 3, 4, 5, 6);
    chk("R8", longint'(y[0]), 32767);
    cycle(0, 0, 1, -9, -9, -9, -9, -9, -9);

    for (int n = 0; n < 3000; n++) begin
      int mode;
      longint a [6];
      mode = $urandom_range(0, 3);
      for (int i = 0; i < 6; i++) begin
        if (mode == 0) a[i] = longint'($signed(24'($urandom())));
        else a[i] = longint'($signed(24'($urandom_range(0, 65535)))) - 32768;
      end
      cycle($urandom_range(0, 4) != 0, $urandom_range(0, 7), $urandom_range(0, 1),
            a[0], a[1], a[2], a[3], a[4], a[5]);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule